// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the one-byte postbyte of an indexed operand into a 16-bit effective address for a small 8-bit processor. A single postbyte selects one of several address forms: a base register plus a short signed constant, an auto-increment or auto-decrement of a base register (pre or post), a base plus an 8-bit-signed or 16-bit constant taken from the instruction stream, a base plus an accumulator, and two indirect forms that fetch a 16-bit pointer from memory.

The processor pulses `start` with the postbyte, the index registers, the program counter and the accumulators. The program counter value is the address that follows the postbyte. When the form needs extension bytes, the block asks for them on a fetch handshake. When the form is indirect, it issues one 16-bit data read. On completion the block pulses `done` and presents the address, the extra-cycle charge and an optional base-register writeback. When a restricted-mode flag is set, the long-offset and offset-indirect forms are refused. In that case the block flags them and returns address zero.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 5 clear, the address is base + sign-extended bits 4:0. Bits 7:6 pick the base (0 X, 1 Y, 2 SP, 3 PC). `done` rises one cycle after `start`, with `extra_cyc` = 0.
- R2: With bit 5 set and bits 7:6 not 11, the form auto-modifies the base register named by bits 7:6. The step is bits 3:0 plus one (+1..+8) when bit 3 is clear. When bit 3 is set, the step is bits 3:0 sign-extended (-8..-1).
- R3: In auto-modify, `wb_val` = base + step and `wb_sel` = bits 7:6. The address is `wb_val` when bit 4 is 0 and the unmodified base when bit 4 is 1.
- R4: `wb_en` is high for exactly one cycle, and only together with `done` of an auto-modify operation.
- R5: A postbyte of the form 111rr0wb selects a constant offset, with the base from bits 4:3. With w=1 a 16-bit word is fetched (`fetch_wide`=1). With w=0 one byte is fetched (`fetch_wide`=0): only `fetch_data[7:0]` is used, and its upper byte is all ones when b=1 and zero when b=0. The address is base + offset, with `extra_cyc` = 1.
- R6: A postbyte of the form 111rr011 fetches a 16-bit offset and reads one word at base + offset on `rd_addr`. The address is `rd_data`, with `extra_cyc` = 1.
- R7: A postbyte of the form 111rr1aa adds a zero-extended A (aa=0), a zero-extended B (aa=1) or D (aa=2), with `extra_cyc` = 0. With aa=3 it reads one word at base + D; the address is `rd_data`, with `extra_cyc` = 1.
- R8: With `restrict_en` set, the forms of R5 and R6 finish one cycle after `start` with `illegal`=1 and address 0. They make no fetch and no read request. All other forms stay legal.
- R9: `fetch_req` stays high, with `fetch_wide` stable, until `fetch_ack`. `rd_req` stays high, with `rd_addr` stable, until `rd_ack`. The two requests are never high together.
- R10: All address arithmetic wraps modulo 2^16.
- R11: A `start` that arrives while an operation is in progress is ignored, and no extra `done` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one address computation |
| postbyte | input | 8 | Indexed-mode postbyte |
| restrict_en | input | 1 | Refuse long-offset and offset-indirect forms |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Address following the postbyte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| fetch_req | output | 1 | Request for extension bytes |
| fetch_wide | output | 1 | 1 = 16-bit word, 0 = single byte |
| fetch_ack | input | 1 | Extension bytes valid |
| fetch_data | input | 16 | Fetched extension bytes |
| rd_req | output | 1 | 16-bit pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 16 | Pointer read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base-register writeback strobe |
| wb_sel | output | 2 | Writeback register (0 X, 1 Y, 2 SP, 3 PC) |
| wb_val | output | 16 | Writeback value |
| extra_cyc | output | 2 | Extra cycles charged |
| illegal | output | 1 | Form refused in restricted mode |

## Verification
The bench builds the block with its defaults: a 16-bit address and 8-bit accumulators. At these widths a 16-bit offset added to a base wraps past 0xFFFF. An accumulator value with its top bit set also shows that A and B are zero-extended, while D is not. Byte offsets are supplied with a nonzero upper byte on the fetch bus, so a design that fails to replace it with the sign byte produces a wrong address. A second `start` is pulsed in the middle of a slow fetch to check that it is ignored.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  typedef enum logic [2:0] {
    FM_K5, FM_AUTO, FM_IND16, FM_OFF9, FM_OFF16, FM_ACC, FM_ACCIND
  } form_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READ} state_e;
endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
  import idx_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [7:0]    pb,
  output form_e         form,
  output logic [1:0]    base_sel,
  output logic [1:0]    acc_sel,
  output logic [AW-1:0] imm,
  output logic          restricted_form
);
  always_comb begin
    form     = FM_K5;
    base_sel = pb[7:6];
    acc_sel  = pb[1:0];
    imm      = {{(AW-5){pb[4]}}, pb[4:0]};
    if (pb[5]) begin
      if (pb[7:6] != 2'b11) begin
        form = FM_AUTO;
        if (pb[3]) imm = {{(AW-4){1'b1}}, pb[3:0]};
        else       imm = {{(AW-4){1'b0}}, pb[3:0]} + {{(AW-1){1'b0}}, 1'b1};
      end else begin
        base_sel = pb[4:3];
        imm      = '0;
        if (pb[2:0] == 3'b011) form = FM_IND16;
        else if (!pb[2])       form = pb[1] ? FM_OFF16 : FM_OFF9;
        else                   form = (pb[1:0] == 2'b11) ? FM_ACCIND : FM_ACC;
      end
    end
  end

  assign restricted_form = (form == FM_IND16) || (form == FM_OFF9) || (form == FM_OFF16);
endmodule

// File: rtl/idx_reg_mux.sv
module idx_reg_mux #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] flat,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   y
);
  logic [W-1:0] arr [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign arr[i] = flat[i*W +: W];
  end

  assign y = arr[sel];
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int AW    = 16,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       postbyte,
  input  logic             restrict_en,
  input  logic [AW-1:0]    reg_x,
  input  logic [AW-1:0]    reg_y,
  input  logic [AW-1:0]    reg_sp,
  input  logic [AW-1:0]    reg_pc,
  input  logic [ACC_W-1:0] acc_a,
  input  logic [ACC_W-1:0] acc_b,
  input  logic [AW-1:0]    acc_d,
  output logic             fetch_req,
  output logic             fetch_wide,
  input  logic             fetch_ack,
  input  logic [AW-1:0]    fetch_data,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [AW-1:0]    rd_data,
  output logic             done,
  output logic [AW-1:0]    ea,
  output logic             wb_en,
  output logic [1:0]       wb_sel,
  output logic [AW-1:0]    wb_val,
  output logic [1:0]       extra_cyc,
  output logic             illegal
);
  localparam int PAD = AW - ACC_W;
  localparam int NREG = 4;

  form_e         form, form_q;
  state_e        state;
  logic [1:0]    base_sel, acc_sel;
  logic [AW-1:0] imm, base_v, acc_v, base_q, off_v, step_sum;
  logic          restricted_form, sign_q;

  idx_pb_decode #(.AW(AW)) u_dec (
    .pb(postbyte), .form(form), .base_sel(base_sel), .acc_sel(acc_sel),
    .imm(imm), .restricted_form(restricted_form)
  );

  idx_reg_mux #(.W(AW), .N(NREG)) u_base_mux (
    .flat({reg_pc, reg_sp, reg_y, reg_x}), .sel(base_sel), .y(base_v)
  );

  idx_reg_mux #(.W(AW), .N(NREG)) u_acc_mux (
    .flat({acc_d, acc_d, {{PAD{1'b0}}, acc_b}, {{PAD{1'b0}}, acc_a}}),
    .sel(acc_sel), .y(acc_v)
  );

  assign step_sum = base_v + imm;
  assign off_v    = fetch_wide ? fetch_data : {{(AW-8){sign_q}}, fetch_data[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      form_q     <= FM_K5;
      base_q     <= '0;
      sign_q     <= 1'b0;
      fetch_req  <= 1'b0;
      fetch_wide <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      done       <= 1'b0;
      ea         <= '0;
      wb_en      <= 1'b0;
      wb_sel     <= '0;
      wb_val     <= '0;
      extra_cyc  <= '0;
      illegal    <= 1'b0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          form_q <= form;
          base_q <= base_v;
          sign_q <= postbyte[0];
          if (restrict_en && restricted_form) begin
            ea        <= '0;
            illegal   <= 1'b1;
            extra_cyc <= 2'd0;
            done      <= 1'b1;
          end else begin
            case (form)
              FM_K5: begin
                ea        <= step_sum;
                illegal   <= 1'b0;
                extra_cyc <= 2'd0;
                done      <= 1'b1;
              end
              FM_AUTO: begin
                ea        <= postbyte[4] ? base_v : step_sum;
                wb_val    <= step_sum;
                wb_sel    <= base_sel;
                wb_en     <= 1'b1;
                illegal   <= 1'b0;
                extra_cyc <= 2'd0;
                done      <= 1'b1;
              end
              FM_ACC: begin
                ea        <= base_v + acc_v;
                illegal   <= 1'b0;
                extra_cyc <= 2'd0;
                done      <= 1'b1;
              end
              FM_ACCIND: begin
                rd_addr <= base_v + acc_v;
                rd_req  <= 1'b1;
                state   <= ST_READ;
              end
              default: begin
                fetch_req  <= 1'b1;
                fetch_wide <= (form != FM_OFF9);
                state      <= ST_FETCH;
              end
            endcase
          end
        end
        ST_FETCH: if (fetch_ack) begin
          fetch_req <= 1'b0;
          if (form_q == FM_IND16) begin
            rd_addr <= base_q + off_v;
            rd_req  <= 1'b1;
            state   <= ST_READ;
          end else begin
            ea        <= base_q + off_v;
            illegal   <= 1'b0;
            extra_cyc <= 2'd1;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_READ: if (rd_ack) begin
          rd_req    <= 1'b0;
          ea        <= rd_data;
          illegal   <= 1'b0;
          extra_cyc <= 2'd1;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done && !illegal);                                   // R4
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (ea == '0) && (extra_cyc == 2'd0));       // R8
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_ack) |=> fetch_req && $stable(fetch_wide)); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr));           // R9
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && rd_req));                                       // R9
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (fetch_req || rd_req) |-> !done);                              // R11
endmodule

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;
  localparam int AW = 16;
  localparam int ACC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] postbyte = 8'h00;
  logic restrict_en = 1'b0;
  logic [AW-1:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0, reg_pc = 16'h8002;
  logic [ACC_W-1:0] acc_a = 8'h85, acc_b = 8'h7F;
  logic [AW-1:0] acc_d = 16'h857F;
  logic fetch_req, fetch_wide, rd_req, done, wb_en, illegal;
  logic fetch_ack = 1'b0, rd_ack = 1'b0;
  logic [AW-1:0] fetch_data = '0, rd_data = '0;
  logic [AW-1:0] rd_addr, ea, wb_val;
  logic [1:0] wb_sel, extra_cyc;

  always #2 clk = ~clk;

  idx_ea_gen #(.AW(AW), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .postbyte(postbyte), .restrict_en(restrict_en),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d),
    .fetch_req(fetch_req), .fetch_wide(fetch_wide), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
    .extra_cyc(extra_cyc), .illegal(illegal)
  );

  typedef struct {
    logic [15:0] ea; logic wb; logic [1:0] sel; logic [15:0] wbv;
    logic [1:0] extra; logic ill; int fk; logic rdx; logic [15:0] rda;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0, dcount = 0;
  int lat = 1, fcnt = 0, rcnt = 0;
  int seen_fk = 0;
  logic seen_rd = 1'b0;
  logic [15:0] seen_rda = '0;
  logic [15:0] fv = '0, rv = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [7:0] pb, input bit rs, input logic [15:0] f, input logic [15:0] r);
    exp_t e;
    logic [15:0] base, step, off;
    logic [15:0] regs [4];
    regs[0] = reg_x; regs[1] = reg_y; regs[2] = reg_sp; regs[3] = reg_pc;
    e = '{ea: 16'h0, wb: 1'b0, sel: 2'd0, wbv: 16'h0, extra: 2'd0, ill: 1'b0, fk: 0, rdx: 1'b0, rda: 16'h0};
    if (!pb[5]) begin
      e.ea = regs[pb[7:6]] + {{11{pb[4]}}, pb[4:0]};
    end else if (pb[7:6] != 2'b11) begin
      base = regs[pb[7:6]];
      step = pb[3] ? {12'hFFF, pb[3:0]} : {12'h000, pb[3:0]} + 16'd1;
      e.wb = 1'b1; e.sel = pb[7:6]; e.wbv = base + step;
      e.ea = pb[4] ? base : base + step;
    end else begin
      base = regs[pb[4:3]];
      if (rs && (pb[2:0] == 3'b011 || !pb[2])) begin
        e.ill = 1'b1;
      end else if (pb[2:0] == 3'b011) begin
        e.fk = 2; e.rdx = 1'b1; e.rda = base + f; e.ea = r; e.extra = 2'd1;
      end else if (!pb[2]) begin
        e.fk = pb[1] ? 2 : 1;
        off = pb[1] ? f : {pb[0] ? 8'hFF : 8'h00, f[7:0]};
        e.ea = base + off; e.extra = 2'd1;
      end else begin
        case (pb[1:0])
          2'd0: e.ea = base + {8'h00, acc_a};
          2'd1: e.ea = base + {8'h00, acc_b};
          2'd2: e.ea = base + acc_d;
          default: begin e.rdx = 1'b1; e.rda = base + acc_d; e.ea = r; e.extra = 2'd1; end
        endcase
      end
    end
    return e;
  endfunction

  // memory-side responder
  always @(negedge clk) begin
    if (fetch_ack) fetch_ack = 1'b0;
    else if (fetch_req) begin
      if (fcnt >= lat) begin
        fetch_ack = 1'b1; fetch_data = fv; seen_fk = fetch_wide ? 2 : 1; fcnt = 0;
      end else fcnt++;
    end
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rcnt >= lat) begin
        rd_ack = 1'b1; rd_data = rv; seen_rd = 1'b1; seen_rda = rd_addr; rcnt = 0;
      end else rcnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      string t;
      dcount++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 64'(ea), 64'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ea == e.ea, {t, " ea"}, 64'(ea), 64'(e.ea));
        chk(illegal == e.ill && extra_cyc == e.extra, {t, " illegal/extra"},
            64'({illegal, extra_cyc}), 64'({e.ill, e.extra}));
        chk(wb_en == e.wb, {t, " R4 wb_en"}, 64'(wb_en), 64'(e.wb));
        if (e.wb) chk(wb_sel == e.sel && wb_val == e.wbv, {t, " R3 writeback"},
                      64'({wb_sel, wb_val}), 64'({e.sel, e.wbv}));
        chk(seen_fk == e.fk, {t, " fetch kind"}, 64'(seen_fk), 64'(e.fk));
        chk(seen_rd == e.rdx, {t, " R9 read issued"}, 64'(seen_rd), 64'(e.rdx));
        if (e.rdx) chk(seen_rda == e.rda, {t, " read addr"}, 64'(seen_rda), 64'(e.rda));
      end
    end
  end

  task automatic run(input logic [7:0] pb, input bit rs, input logic [15:0] f,
                     input logic [15:0] r, input bit poke, input string tag);
    int n;
    exp_q.push_back(model(pb, rs, f, r));
    tag_q.push_back(tag);
    n = dcount;
    seen_fk = 0; seen_rd = 1'b0; fv = f; rv = r;
    @(negedge clk);
    postbyte = pb; restrict_en = rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      postbyte = 8'h05; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (dcount == n) @(negedge clk);
    @(negedge clk);
    chk(!wb_en, {tag, " R4 wb_en one cycle"}, 64'(wb_en), 64'h0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fetch_req && !rd_req && !wb_en && ea == 16'h0, "R9 reset state",
        64'({done, fetch_req, rd_req, wb_en, ea}), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1 short constant
    run(8'h05, 1'b0, 16'h0, 16'h0, 1'b0, "R1 X+5");
    run(8'h5F, 1'b0, 16'h0, 16'h0, 1'b0, "R1 Y-1");
    run(8'hD0, 1'b0, 16'h0, 16'h0, 1'b0, "R1 PC-16");
    run(8'h8F, 1'b0, 16'h0, 16'h0, 1'b0, "R1 SP+15");
    // R2/R3 auto-modify
    run(8'h20, 1'b0, 16'h0, 16'h0, 1'b0, "R2 R3 pre +1 X");
    run(8'h77, 1'b0, 16'h0, 16'h0, 1'b0, "R2 R3 post +8 Y");
    run(8'hA8, 1'b0, 16'h0, 16'h0, 1'b0, "R2 R3 pre -8 SP");
    run(8'h3F, 1'b0, 16'h0, 16'h0, 1'b0, "R2 R3 post -1 X");
    // R5 constant offsets, junk upper byte on byte fetch
    run(8'hE8, 1'b0, 16'hAB40, 16'h0, 1'b0, "R5 byte +0x40 Y");
    run(8'hF1, 1'b0, 16'h5A10, 16'h0, 1'b0, "R5 byte neg SP");
    lat = 3;
    run(8'hE2, 1'b0, 16'hF000, 16'h0, 1'b0, "R5 R10 word wrap X");
    // R6 indirect
    run(8'hFB, 1'b0, 16'h0010, 16'hBEEF, 1'b0, "R6 indirect PC");
    lat = 1;
    // R7 accumulators
    run(8'hE4, 1'b0, 16'h0, 16'h0, 1'b0, "R7 X+A");
    run(8'hED, 1'b0, 16'h0, 16'h0, 1'b0, "R7 Y+B");
    run(8'hF6, 1'b0, 16'h0, 16'h0, 1'b0, "R7 SP+D");
    run(8'hE7, 1'b0, 16'h0, 16'h1234, 1'b0, "R7 [D,X]");
    // R8 restricted
    run(8'hFB, 1'b1, 16'h0010, 16'hBEEF, 1'b0, "R8 refuse indirect");
    run(8'hE2, 1'b1, 16'h1111, 16'h0, 1'b0, "R8 refuse word offset");
    run(8'hE8, 1'b1, 16'h0022, 16'h0, 1'b0, "R8 refuse byte offset");
    run(8'h05, 1'b1, 16'h0, 16'h0, 1'b0, "R8 short allowed");
    run(8'hE7, 1'b1, 16'h0, 16'h4321, 1'b0, "R8 [D,X] allowed");
    // R10 wrap in auto-modify
    reg_x = 16'hFFFF;
    run(8'h20, 1'b0, 16'h0, 16'h0, 1'b0, "R10 pre +1 wrap");
    reg_x = 16'h1000;
    // R11 start while busy
    lat = 4;
    run(8'hE2, 1'b0, 16'h0200, 16'h0, 1'b1, "R11 busy ignores start");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && dcount == 23, "R11 done count",
        64'(dcount), 64'd23);
    summary();
  end
endmodule